// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block performs load-multiple and store-multiple operations for a processor datapath. A single start pulse hands it a base address, a register selection mask with one bit per architectural register, an addressing mode, a load/store select and a writeback request. The sequencer then steps through the selected registers from the lowest index to the highest and issues one word access per register on a simple memory port, reading store data from, or writing load data back to, a register file port.

The four modes differ only in where the block of words sits relative to the base: ascending from the base, ascending from one word above it, ending at the base, or ending one word below it. In every mode the lowest-numbered selected register lands at the lowest address of the block, so the sequencer first computes that lowest address, using a population count of the mask for the decrementing modes, and then always walks upward. On completion it reports the updated base value and whether the base register is to be written.

Top module: `blkxfer_seq`

## Requirements
- R1: With mode 0 (ascending, post-step) the first access goes to the base address and each following access goes 4 bytes higher, one per set mask bit, in ascending register index order.
- R2: With mode 1 (ascending, pre-step) the first access goes to base + 4 and each following access goes 4 bytes higher, in ascending register index order.
- R3: With mode 2 (descending, post-step) the accesses cover base - 4*N + 4 up to base in ascending register order, N being the number of set mask bits, so the highest selected register is at the base.
- R4: With mode 3 (descending, pre-step) the accesses cover base - 4*N up to base - 4 in ascending register order.
- R5: In the cycle `done` is high, if writeback was requested `base_wr` is 1 and `base_out` is base + 4*N for modes 0 and 1 or base - 4*N for modes 2 and 3; without writeback `base_wr` is 0 and `base_out` equals the base.
- R6: A store (`is_load` = 0) drives `mem_we` = 1 and, for each access, `mem_wdata` equal to the register file word for the register index of that access.
- R7: A load drives `mem_we` = 0; one cycle after each request `rf_we` is 1, `rf_waddr` is that access's register index and `rf_wdata` is the word the memory returned for it.
- R8: Requests occupy consecutive cycles, the first one two cycles after the start cycle; `busy` is high from the cycle after start through the last request, and `done` pulses for one cycle right after the last request, with `busy` low.
- R9: An all-zero mask produces `done` in the cycle after start with no memory request, no register write, `base_wr` = 0 and `base_out` equal to the base.
- R10: A start pulse while `busy` is high is ignored: the operation in flight keeps its addresses, registers and writeback result.
- R11: After reset `busy`, `done`, `mem_req`, `rf_we` and `base_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| base_in | input | 32 | Base address |
| mask_in | input | 16 | Register selection mask, bit i selects register i |
| mode_in | input | 2 | 0 asc post, 1 asc pre, 2 desc post, 3 desc pre |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Resulting base value, valid with done |
| base_wr | output | 1 | Base register write enable, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data for rf_raddr |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
The bench aims at the decrementing modes with sparse and full masks, where a design that walked downward or skipped the population count would put registers at mirrored or shifted addresses and the base register at the wrong end of the block. Masks with only the top or bottom bit set and the all-zero mask probe the priority encoder and the empty path, where a faulty design would issue a stray access or report a moved base. A start pulse injected mid-operation would, in a design that re-sampled it, corrupt the remaining addresses or the writeback value, and load operations check that the returned word reaches the index of the access that fetched it, one cycle later, which catches an off-by-one in the load pipeline.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    MODE_ASC_POST  = 2'd0,
    MODE_ASC_PRE   = 2'd1,
    MODE_DESC_POST = 2'd2,
    MODE_DESC_PRE  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int NREG = 16,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  output logic [CW-1:0]   count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CW'(mask[i]);
    end
  end

  always_comb begin
    assert_cnt_bound_R3: assert (count <= CW'(NREG));
  end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IDXW-1:0] idx,
  output logic            single
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDXW'(i);
    end
  end

  assign single = (mask != '0) && ((mask & (mask - NREG'(1))) == '0);

  always_comb begin
    if (mask != '0) begin
      assert_pick_set_R1: assert (mask[idx]);
    end
  end
endmodule

// File: rtl/blkxfer_addrgen.sv
module blkxfer_addrgen
  import blkxfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int CW  = $clog2(NREG + 1),
  localparam int WORD_BYTES = 4
) (
  input  logic [AW-1:0] base,
  input  xfer_mode_e    mode,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] next_base
);
  logic [AW-1:0] span;
  logic [AW-1:0] step;

  assign span = AW'(count) * AW'(WORD_BYTES);
  assign step = AW'(WORD_BYTES);

  always_comb begin
    unique case (mode)
      MODE_ASC_POST:  first_addr = base;
      MODE_ASC_PRE:   first_addr = base + step;
      MODE_DESC_POST: first_addr = base - span + step;
      default:        first_addr = base - span;
    endcase
    if (mode == MODE_ASC_POST || mode == MODE_ASC_PRE) next_base = base + span;
    else                                               next_base = base - span;
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG),
  localparam int CW   = $clog2(NREG + 1),
  localparam int WORD_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   base_in,
  input  logic [NREG-1:0] mask_in,
  input  logic [1:0]      mode_in,
  input  logic            is_load,
  input  logic            wb_en,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   base_out,
  output logic            base_wr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IDXW-1:0] rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IDXW-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata
);
  seq_state_e      state;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   wbval_q;
  logic            wbreq_q;
  logic            load_q;
  logic [IDXW-1:0] beat_idx_q;

  logic [CW-1:0]   sel_count;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   next_base;
  logic [IDXW-1:0] cur_idx;
  logic            last_beat;

  blkxfer_popcnt #(.NREG(NREG)) u_popcnt (
    .mask  (mask_in),
    .count (sel_count)
  );

  blkxfer_addrgen #(.AW(AW), .NREG(NREG)) u_addrgen (
    .base       (base_in),
    .mode       (xfer_mode_e'(mode_in)),
    .count      (sel_count),
    .first_addr (first_addr),
    .next_base  (next_base)
  );

  blkxfer_lowbit #(.NREG(NREG)) u_lowbit (
    .mask   (mask_q),
    .idx    (cur_idx),
    .single (last_beat)
  );

  assign rf_raddr = cur_idx;
  assign rf_wdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mask_q     <= '0;
      addr_q     <= '0;
      base_q     <= '0;
      wbval_q    <= '0;
      wbreq_q    <= 1'b0;
      load_q     <= 1'b0;
      beat_idx_q <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      base_out   <= '0;
      base_wr    <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
    end else begin
      done     <= 1'b0;
      base_wr  <= 1'b0;
      mem_req  <= 1'b0;
      rf_we    <= mem_req & ~mem_we;
      rf_waddr <= beat_idx_q;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (mask_in == '0) begin
              done     <= 1'b1;
              base_out <= base_in;
            end else begin
              mask_q  <= mask_in;
              addr_q  <= first_addr;
              base_q  <= base_in;
              wbval_q <= next_base;
              wbreq_q <= wb_en;
              load_q  <= is_load;
              busy    <= 1'b1;
              state   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          mem_req    <= 1'b1;
          mem_we     <= ~load_q;
          mem_addr   <= addr_q;
          mem_wdata  <= rf_rdata;
          beat_idx_q <= cur_idx;
          mask_q     <= mask_q & ~(NREG'(1) << cur_idx);
          addr_q     <= addr_q + AW'(WORD_BYTES);
          if (last_beat) state <= ST_FIN;
        end
        default: begin
          busy     <= 1'b0;
          done     <= 1'b1;
          base_wr  <= wbreq_q;
          base_out <= wbreq_q ? wbval_q : base_q;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(WORD_BYTES)));
  assert_dir_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_we == $past(mem_we)));
  assert_load_wr_R7: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(mem_req && !mem_we));
  assert_idle_clean_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !mem_req);
endmodule

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] base_in;
  logic [15:0] mask_in;
  logic [1:0]  mode_in;
  logic        is_load;
  logic        wb_en;
  logic        busy, done, base_wr, mem_req, mem_we, rf_we;
  logic [31:0] base_out, mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0]  rf_raddr, rf_waddr;

  logic [31:0] mem_m [256];
  logic [31:0] rf_m  [16];

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blkxfer_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .base_in(base_in), .mask_in(mask_in),
    .mode_in(mode_in), .is_load(is_load), .wb_en(wb_en), .busy(busy), .done(done),
    .base_out(base_out), .base_wr(base_wr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata)
  );

  assign rf_rdata = rf_m[rf_raddr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= 32'hA5000000 ^ (i * 32'h01010101);
      for (int i = 0; i < 16; i++)  rf_m[i]  <= 32'h11110000 + i * 32'h00000111;
      mem_rdata <= '0;
    end else begin
      if (mem_req && mem_we) mem_m[mem_addr[9:2]] <= mem_wdata;
      if (mem_req) mem_rdata <= mem_m[mem_addr[9:2]];
      if (rf_we) rf_m[rf_waddr] <= rf_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] low_addr(input logic [31:0] b, input logic [1:0] m, input int c);
    case (m)
      2'd0: return b;
      2'd1: return b + 4;
      2'd2: return b - 32'(4 * c) + 4;
      default: return b - 32'(4 * c);
    endcase
  endfunction

  function automatic logic [31:0] wb_value(input logic [31:0] b, input logic [1:0] m, input int c);
    return (m < 2) ? b + 32'(4 * c) : b - 32'(4 * c);
  endfunction

  function automatic string mreq(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_op(input logic [31:0] b, input logic [15:0] msk, input logic [1:0] m,
                        input bit ld, input bit wb, input bit inject);
    int cnt = 0;
    int idx_l [16];
    logic [31:0] lo, a, pa;
    int pidx;
    for (int i = 0; i < 16; i++) if (msk[i]) begin idx_l[cnt] = i; cnt++; end
    lo = low_addr(b, m, cnt);
    @(negedge clk);
    base_in = b; mask_in = msk; mode_in = m; is_load = ld; wb_en = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      chk(done == 1'b1, "R9 done", 32'(done), 32'd1);
      chk(mem_req == 1'b0 && rf_we == 1'b0, "R9 no access", 32'({mem_req, rf_we}), 32'd0);
      chk(base_wr == 1'b0 && base_out == b, "R9 base", base_out, b);
      return;
    end
    chk(busy == 1'b1 && mem_req == 1'b0, "R8 busy before first request", 32'({busy, mem_req}), 32'h2);
    if (inject) begin
      start = 1'b1; mask_in = ~msk; mode_in = m ^ 2'd3; base_in = b ^ 32'h40; is_load = ~ld; wb_en = ~wb;
    end
    pa = '0; pidx = 0;
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      start = 1'b0;
      a = lo + 32'(4 * k);
      chk(mem_req == 1'b1 && busy == 1'b1 && done == 1'b0, "R8 request beat", 32'({mem_req, busy, done}), 32'h6);
      chk(mem_addr == a, inject ? "R10 address" : mreq(m), mem_addr, a);
      chk(mem_we == !ld, ld ? "R7 direction" : "R6 direction", 32'(mem_we), 32'(!ld));
      if (!ld) begin
        chk(mem_wdata == rf_m[idx_l[k]], "R6 store data", mem_wdata, rf_m[idx_l[k]]);
        chk(rf_we == 1'b0, "R6 no register write", 32'(rf_we), 32'd0);
      end else if (k > 0) begin
        chk(rf_we == 1'b1 && rf_waddr == 4'(pidx), "R7 write index", 32'({rf_we, rf_waddr}), 32'({1'b1, 4'(pidx)}));
        chk(rf_wdata == mem_m[pa[9:2]], "R7 write data", rf_wdata, mem_m[pa[9:2]]);
      end
      pa = a; pidx = idx_l[k];
    end
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0 && mem_req == 1'b0, "R8 done pulse", 32'({done, busy, mem_req}), 32'h4);
    if (ld) begin
      chk(rf_we == 1'b1 && rf_waddr == 4'(pidx), "R7 last write index", 32'({rf_we, rf_waddr}), 32'({1'b1, 4'(pidx)}));
      chk(rf_wdata == mem_m[pa[9:2]], "R7 last write data", rf_wdata, mem_m[pa[9:2]]);
    end
    chk(base_wr == wb, inject ? "R10 writeback flag" : "R5 writeback flag", 32'(base_wr), 32'(wb));
    chk(base_out == (wb ? wb_value(b, m, cnt) : b), inject ? "R10 base" : "R5 base",
        base_out, wb ? wb_value(b, m, cnt) : b);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && mem_req == 1'b0, "R8 single done", 32'({done, busy, mem_req}), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; start = 1'b0; base_in = '0; mask_in = '0; mode_in = '0; is_load = 1'b0; wb_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, mem_req, rf_we, base_wr} == 5'b0, "R11 reset outputs",
        32'({busy, done, mem_req, rf_we, base_wr}), 32'd0);
    rst = 1'b0;
    run_op(32'h100, 16'h000F, 2'd0, 1'b0, 1'b1, 1'b0);
    run_op(32'h200, 16'h001E, 2'd2, 1'b0, 1'b1, 1'b0);
    run_op(32'h300, 16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b0);
    run_op(32'h180, 16'h8001, 2'd1, 1'b1, 1'b0, 1'b0);
    run_op(32'h240, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0);
    run_op(32'h2C0, 16'h8000, 2'd2, 1'b1, 1'b1, 1'b0);
    run_op(32'h140, 16'h0A50, 2'd3, 1'b0, 1'b0, 1'b1);
    r = $urandom(32'd20240611);
    for (int t = 0; t < 160; t++) begin
      logic [15:0] m;
      r = $urandom;
      m = (r[3:0] == 4'd0) ? 16'h0 : (r[4] ? 16'(r[31:16]) : (16'(r[31:16]) & 16'h0111));
      run_op(32'h400 + {22'd0, r[13:6], 2'b00}, m, r[1:0] ^ r[15:14], r[2], r[5], (t % 9) == 4);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule